// File: doc/BRIEF.md
# Debug Status and Control Register

This block is the single byte-wide status and control register of a background debug controller. It sits at one bus address and can be written by the CPU bus or by the serial debug command path. Each field has its own write permission. Some fields can always be written. The active-debug field can be written only by host-issued commands, and the clock-switch field only by firmware-issued commands. The host/firmware distinction comes from the top bit of the debug command being executed, and the block receives it as a single flag.

The active-debug field drives the memory map. While it is set, the debug ROM and the debug registers are visible to the CPU. Hardware sets it when an entry request arrives, but only if the enable field is set. It clears a fixed number of clocks after a clearing store, so the firmware exit routine can finish its last instructions before the ROM leaves the map. The reset value of the active field depends on the chip's operating-mode group, which is sampled on the reset clock edge.

Top module: `dbg_stat_reg`

## Requirements
- R1: A clock edge with `rst_n` low loads 0x40 (active bit 6 set, all other bits clear) when `mode_special` is 1, and 0x00 when it is 0.
- R2: A write that hits the register address loads bit 7 (enable), bit 5 (tag enable), bit 4 (data valid) and bit 3 (trace) from the data, whatever the value of `cmd_fw`.
- R3: Bit 2 (clock switch) takes the written value only when `cmd_fw` is 1. When `cmd_fw` is 0, the write leaves bit 2 unchanged.
- R4: Bit 6 (active) is writable only when `cmd_fw` is 0. Writing a 1 there sets it at the write edge. When `cmd_fw` is 1, the write leaves bit 6 unchanged.
- R5: A clearing write to bit 6 (with `cmd_fw` 0) sampled at edge k keeps `dbg_active` at 1 through edge k+3 and drops it at edge k+4. A newer clearing write restarts the count.
- R6: Bits 1 and 0 always read 0, including after writes of ones.
- R7: A write to any address other than 0xFF01 changes no bit.
- R8: `enter_req` sets bit 6 at the next edge when bit 7 is 1. When bit 7 is 0, the request has no effect.
- R9: An accepted entry request, or a write of 1 to bit 6, in the same cycle as a clearing write or during a pending clear, leaves bit 6 at 1 and cancels the pending clear.
- R10: A pulse on `fw_exit` clears bit 6 with the same delay as R5, independent of `cmd_fw`.
- R11: `dbg_en`, `dbg_active`, `trace_en` and `clk_sw` equal bits 7, 6, 3 and 2 of `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_special | input | 1 | 1 = special single-chip or peripheral mode group |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 16 | Write address |
| bus_wdata | input | 8 | Write data |
| cmd_fw | input | 1 | Host/firmware flag of the current debug command (1 = firmware) |
| enter_req | input | 1 | Hardware request to enter active debug |
| fw_exit | input | 1 | Firmware exit store; starts the delayed clear of active |
| rd_data | output | 8 | Register readback |
| dbg_en | output | 1 | Debug entry enabled |
| dbg_active | output | 1 | Active debug; debug ROM and registers are mapped |
| trace_en | output | 1 | Trace control |
| clk_sw | output | 1 | Clock-switch control |

## Verification
The permission logic is tested in both mode groups. Each host/firmware flag value is combined with all-ones, all-zeros and two alternating data patterns. The alternating patterns show whether a field is gated by the flag or shares its enable with a neighbouring field. The all-ones and all-zeros patterns show whether the unused bits stay at 0. A clearing write is followed by idle cycles while `dbg_active` is sampled on every edge, which pins down the exact edge on which the ROM leaves the map. Entry requests are then placed with the enable bit clear, with it set, on the clearing edge itself and in the middle of the delay, which separates a refused entry, an accepted entry and a cancelled clear.

// File: rtl/dbg_stat_pkg.sv
package dbg_stat_pkg;
   localparam int REG_W   = 8;
   localparam int B_EN    = 7;
   localparam int B_ACT   = 6;
   localparam int B_TAG   = 5;
   localparam int B_VALID = 4;
   localparam int B_TRACE = 3;
   localparam int B_CSW   = 2;

   // permission classes per bit
   localparam logic [REG_W-1:0] ANY_MASK  = 8'hB8;
   localparam logic [REG_W-1:0] HOST_MASK = 8'h40;
   localparam logic [REG_W-1:0] FW_MASK   = 8'h04;
   localparam logic [REG_W-1:0] STORE_MASK = ANY_MASK | FW_MASK;

   typedef enum logic {
      GRP_NORMAL  = 1'b0,
      GRP_SPECIAL = 1'b1
   } mode_grp_e;

   typedef struct packed {
      logic set_act;
      logic clr_act;
   } act_req_t;
endpackage

// File: rtl/dbg_wr_gate.sv
module dbg_wr_gate
   import dbg_stat_pkg::*;
#(
   parameter int                ADDR_W   = 16,
   parameter logic [31:0]       REG_ADDR = 32'h0000_FF01,
   parameter logic [REG_W-1:0]  ANY_M    = ANY_MASK,
   parameter logic [REG_W-1:0]  HOST_M   = HOST_MASK,
   parameter logic [REG_W-1:0]  FW_M     = FW_MASK
) (
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              act_wval,
   input  logic              cmd_fw,
   input  logic              fw_exit,
   output logic [REG_W-1:0]  wen,
   output act_req_t          act_req
);
   localparam logic [ADDR_W-1:0] MATCH = REG_ADDR[ADDR_W-1:0];

   logic hit;
   assign hit = bus_wr && (bus_addr == MATCH);

   for (genvar i = 0; i < REG_W; i++) begin : g_perm
      if (ANY_M[i]) begin : g_any
         assign wen[i] = hit;
      end else if (HOST_M[i]) begin : g_host
         assign wen[i] = hit && !cmd_fw;
      end else if (FW_M[i]) begin : g_fw
         assign wen[i] = hit && cmd_fw;
      end else begin : g_none
         assign wen[i] = 1'b0;
      end
   end

   assign act_req.set_act = wen[B_ACT] && act_wval;
   assign act_req.clr_act = (wen[B_ACT] && !act_wval) || fw_exit;
endmodule

// File: rtl/dbg_field_bank.sv
module dbg_field_bank
   import dbg_stat_pkg::*;
#(
   parameter logic [REG_W-1:0] STORE_M = STORE_MASK
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] wen,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] q
);
   for (genvar i = 0; i < REG_W; i++) begin : g_bit
      if (STORE_M[i]) begin : g_ff
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      bit_q <= 1'b0;
            else if (wen[i]) bit_q <= wdata[i];
         end
         assign q[i] = bit_q;
      end else begin : g_zero
         // unstored bit: inputs referenced, result forced to zero
         assign q[i] = wen[i] & wdata[i] & 1'b0;
      end
   end
endmodule

// File: rtl/dbg_active_ctl.sv
module dbg_active_ctl
   import dbg_stat_pkg::*;
#(
   parameter int CLR_DELAY = 4,
   localparam int CNT_W = (CLR_DELAY < 2) ? 1 : $clog2(CLR_DELAY)
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     rst_val,
   input  logic     en,
   input  logic     enter_req,
   input  act_req_t req,
   output logic     active
);
   logic take;
   assign take = (enter_req && en) || req.set_act;

   if (CLR_DELAY == 0) begin : g_imm
      always_ff @(posedge clk) begin
         if (!rst_n)           active <= rst_val;
         else if (take)        active <= 1'b1;
         else if (req.clr_act) active <= 1'b0;
      end
   end else begin : g_dly
      localparam logic [CNT_W-1:0] LOAD = CNT_W'(CLR_DELAY - 1);
      logic             pend;
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            active <= rst_val;
            pend   <= 1'b0;
            cnt    <= '0;
         end else if (take) begin
            active <= 1'b1;
            pend   <= 1'b0;
         end else if (req.clr_act) begin
            pend <= 1'b1;
            cnt  <= LOAD;
         end else if (pend && cnt == '0) begin
            active <= 1'b0;
            pend   <= 1'b0;
         end else if (pend) begin
            cnt <= cnt - 1'b1;
         end
      end
   end
endmodule

// File: rtl/dbg_stat_reg.sv
module dbg_stat_reg
   import dbg_stat_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter logic [31:0] REG_ADDR  = 32'h0000_FF01,
   parameter int          CLR_DELAY = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_special,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   input  logic              cmd_fw,
   input  logic              enter_req,
   input  logic              fw_exit,
   output logic [REG_W-1:0]  rd_data,
   output logic              dbg_en,
   output logic              dbg_active,
   output logic              trace_en,
   output logic              clk_sw
);
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_aw
      $error("dbg_stat_reg: ADDR_W out of range");
   end
   if (ADDR_W < 32 && (REG_ADDR >> ADDR_W) != 0) begin : g_bad_addr
      $error("dbg_stat_reg: REG_ADDR wider than ADDR_W");
   end
   if (CLR_DELAY < 0 || CLR_DELAY > 255) begin : g_bad_dly
      $error("dbg_stat_reg: CLR_DELAY out of range");
   end
   if ((ANY_MASK & HOST_MASK) != 0 || (ANY_MASK & FW_MASK) != 0) begin : g_bad_mask
      $error("dbg_stat_reg: overlapping permission masks");
   end

   logic [REG_W-1:0] wen;
   logic [REG_W-1:0] field_q;
   act_req_t         act_req;
   logic             act_q;
   mode_grp_e        grp;

   assign grp = mode_grp_e'(mode_special);

   dbg_wr_gate #(
      .ADDR_W  (ADDR_W),
      .REG_ADDR(REG_ADDR)
   ) u_gate (
      .bus_wr  (bus_wr),
      .bus_addr(bus_addr),
      .act_wval(bus_wdata[B_ACT]),
      .cmd_fw  (cmd_fw),
      .fw_exit (fw_exit),
      .wen     (wen),
      .act_req (act_req)
   );

   dbg_field_bank #(
      .STORE_M(STORE_MASK)
   ) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .wen  (wen),
      .wdata(bus_wdata),
      .q    (field_q)
   );

   dbg_active_ctl #(
      .CLR_DELAY(CLR_DELAY)
   ) u_act (
      .clk      (clk),
      .rst_n    (rst_n),
      .rst_val  (grp == GRP_SPECIAL),
      .en       (field_q[B_EN]),
      .enter_req(enter_req),
      .req      (act_req),
      .active   (act_q)
   );

   always_comb begin
      rd_data        = field_q;
      rd_data[B_ACT] = act_q;
   end

   assign dbg_en     = field_q[B_EN];
   assign dbg_active = act_q;
   assign trace_en   = field_q[B_TRACE];
   assign clk_sw     = field_q[B_CSW];
endmodule

// File: rtl/dbg_stat_reg_chk.sv
module dbg_stat_reg_chk #(
   parameter int          ADDR_W    = 16,
   parameter logic [31:0] REG_ADDR  = 32'h0000_FF01,
   parameter int          CLR_DELAY = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_special,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_wdata,
   input logic              cmd_fw,
   input logic              enter_req,
   input logic [7:0]        rd_data,
   input logic              dbg_en,
   input logic              dbg_active,
   input logic              clk_sw
);
   logic hit;
   assign hit = bus_wr && (bus_addr == REG_ADDR[ADDR_W-1:0]);

   // R1
   reset_val_chk: assert property (@(posedge clk)
      !rst_n |=> rd_data == ($past(mode_special) ? 8'h40 : 8'h00));

   // R2
   any_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> {rd_data[7], rd_data[5:3]} == $past({bus_wdata[7], bus_wdata[5:3]}));

   // R3
   csw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !cmd_fw) |=> $stable(clk_sw));

   // R3
   csw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && cmd_fw) |=> clk_sw == $past(bus_wdata[2]));

   // R4
   act_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !cmd_fw && bus_wdata[6]) |=> dbg_active);

   // R5
   clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (CLR_DELAY > 0 && hit && !cmd_fw && !bus_wdata[6] && dbg_active) |=> dbg_active);

   // R6
   unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && |bus_wdata[1:0]) |=> rd_data[1:0] == 2'b00);

   // R8
   refuse_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enter_req && !dbg_en && !dbg_active && !(hit && !cmd_fw && bus_wdata[6]))
      |=> !dbg_active);

   // R9
   entry_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enter_req && dbg_en) |=> dbg_active);
endmodule

bind dbg_stat_reg dbg_stat_reg_chk #(
   .ADDR_W   (ADDR_W),
   .REG_ADDR (REG_ADDR),
   .CLR_DELAY(CLR_DELAY)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_special(mode_special),
   .bus_wr      (bus_wr),
   .bus_addr    (bus_addr),
   .bus_wdata   (bus_wdata),
   .cmd_fw      (cmd_fw),
   .enter_req   (enter_req),
   .rd_data     (rd_data),
   .dbg_en      (dbg_en),
   .dbg_active  (dbg_active),
   .clk_sw      (clk_sw)
);

// File: tb/dbg_stat_reg_tb.sv
`timescale 1ns/1ps
module dbg_stat_reg_tb;
   localparam logic [15:0] ADDR = 16'hFF01;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_special = 1'b0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        cmd_fw = 1'b0;
   logic        enter_req = 1'b0;
   logic        fw_exit = 1'b0;
   logic [7:0]  rd_data;
   logic        dbg_en, dbg_active, trace_en, clk_sw;

   int n_chk = 0;
   int n_err = 0;

   typedef struct {
      logic [7:0] v;
      string      tag;
   } exp_t;
   exp_t sb[$];

   // requirement model state
   logic [7:0] m_reg = 8'h00;
   logic       m_pend = 1'b0;
   int         m_cnt = 0;

   always #5 clk = ~clk;

   dbg_stat_reg u_dut (
      .clk(clk), .rst_n(rst_n), .mode_special(mode_special),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .cmd_fw(cmd_fw), .enter_req(enter_req), .fw_exit(fw_exit),
      .rd_data(rd_data), .dbg_en(dbg_en), .dbg_active(dbg_active),
      .trace_en(trace_en), .clk_sw(clk_sw)
   );

   task automatic fail(string tag, string what, logic [7:0] act, logic [7:0] exp);
      n_err++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
   endtask

   // monitor: compares every result after the edge it belongs to
   always @(posedge clk) begin
      #2;
      while (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         n_chk++;
         if (rd_data !== e.v) fail(e.tag, "rd_data", rd_data, e.v);
         n_chk++;
         if ({dbg_en, dbg_active, trace_en, clk_sw} !== {e.v[7], e.v[6], e.v[3], e.v[2]})
            fail("R11", "flag outputs", {4'h0, dbg_en, dbg_active, trace_en, clk_sw},
                 {4'h0, e.v[7], e.v[6], e.v[3], e.v[2]});
      end
   end

   // driver: one clock of stimulus, model advanced, expectation queued
   task automatic step(input logic rn, input logic wr, input logic [15:0] a,
                       input logic [7:0] d, input logic fw, input logic ent,
                       input logic ex, input string tag);
      logic hit, take, clr;
      logic [7:0] nx;
      @(negedge clk);
      rst_n = rn; bus_wr = wr; bus_addr = a; bus_wdata = d;
      cmd_fw = fw; enter_req = ent; fw_exit = ex;
      @(posedge clk);
      if (!rn) begin
         m_reg = mode_special ? 8'h40 : 8'h00;
         m_pend = 1'b0;
      end else begin
         hit = wr && (a == ADDR);
         nx = m_reg;
         if (hit) begin
            nx[7] = d[7]; nx[5] = d[5]; nx[4] = d[4]; nx[3] = d[3];
            if (fw) nx[2] = d[2];
         end
         take = (ent && m_reg[7]) || (hit && !fw && d[6]);
         clr  = (hit && !fw && !d[6]) || ex;
         if (take) begin
            nx[6] = 1'b1; m_pend = 1'b0;
         end else if (clr) begin
            m_pend = 1'b1; m_cnt = 3;
         end else if (m_pend && m_cnt == 0) begin
            nx[6] = 1'b0; m_pend = 1'b0;
         end else if (m_pend) begin
            m_cnt--;
         end
         m_reg = nx;
      end
      sb.push_back('{v: m_reg, tag: tag});
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1, 0, 16'h0, 8'h00, 0, 0, 0, tag);
   endtask

   task automatic wr(input logic [7:0] d, input logic fw, input string tag);
      step(1, 1, ADDR, d, fw, 0, 0, tag);
   endtask

   task automatic chk_act(input logic exp, input string tag);
      #1;
      n_chk++;
      if (dbg_active !== exp) fail(tag, "dbg_active", {7'h0, dbg_active}, {7'h0, exp});
   endtask

   initial begin
      logic [7:0] pats [4];
      pats[0] = 8'hFF; pats[1] = 8'h00; pats[2] = 8'hAA; pats[3] = 8'h55;
      for (int md = 0; md < 2; md++) begin
         mode_special = md[0];
         step(0, 0, 16'h0, 8'h00, 0, 0, 0, "R1");
         step(0, 0, 16'h0, 8'h00, 0, 0, 0, "R1");
         idle(1, "R1");
         for (int fw = 0; fw < 2; fw++) begin
            for (int p = 0; p < 4; p++) begin
               // R2 R3 R4 R6 permission sweep
               wr(pats[p], fw[0], fw[0] ? "R2 R3 R6" : "R2 R3 R4 R6");
               idle(5, "R5");
            end
         end
      end

      // R7: other addresses leave the register alone
      wr(8'h00, 0, "R4");
      idle(5, "R5");
      step(1, 1, 16'hFF00, 8'hFF, 0, 0, 0, "R7");
      step(1, 1, 16'hFF02, 8'hFF, 1, 0, 0, "R7");

      // R8: refused entry, then accepted entry
      step(1, 0, 16'h0, 8'h00, 0, 1, 0, "R8");
      chk_act(1'b0, "R8");
      wr(8'h80, 1, "R2");
      step(1, 0, 16'h0, 8'h00, 0, 1, 0, "R8");
      chk_act(1'b1, "R8");

      // R5: exact removal edge after a clearing write
      wr(8'h80, 0, "R5");
      chk_act(1'b1, "R5");
      for (int k = 1; k <= 4; k++) begin
         idle(1, "R5");
         chk_act(k < 4, "R5");
      end

      // R9: entry during a pending clear cancels it
      wr(8'hC0, 0, "R4");
      wr(8'h80, 0, "R5");
      idle(2, "R5");
      step(1, 0, 16'h0, 8'h00, 0, 1, 0, "R9");
      idle(6, "R9");
      chk_act(1'b1, "R9");

      // R9: entry on the same edge as the clearing write
      step(1, 1, ADDR, 8'h80, 0, 1, 0, "R9");
      idle(6, "R9");
      chk_act(1'b1, "R9");

      // R10: exit store with firmware flag set
      step(1, 0, 16'h0, 8'h00, 1, 0, 1, "R10");
      idle(3, "R10");
      chk_act(1'b1, "R10");
      idle(1, "R10");
      chk_act(1'b0, "R10");

      // R4: firmware-flagged write of 1 to bit 6 is ignored
      wr(8'hC0, 1, "R4");
      chk_act(1'b0, "R4");
      idle(2, "R11");

      #20;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #500000;
      n_err++;
      $display("FAIL watchdog R1..: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule